// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the slave side of a two-wire serial bus that sits in front of a small on-chip data store. A fast system clock oversamples the bus clock and data pins. The block finds START and STOP conditions on the sampled lines and moves bytes MSB-first across the bus. It answers on the bus through a single open-drain pull-down enable. A master uses it to write one or more bytes at a chosen address, to set an address and read it back, and to read several bytes in a row. The store is a 16-entry array of bytes.

Every completed write ends with a STOP, and that STOP starts a timed internal programming cycle. While the cycle runs, the block ignores attempts to address it and gives no acknowledge. The internal address pointer is shared by writes and reads. It advances after every byte and wraps at the end of the array. When the master declines to acknowledge a read byte, the read is over: the block lets go of the data line and waits for the next bus condition.

Top module: `eep_2w_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, the block waits for a START, and every array entry reads as 0x00 with the pointer at 0.
- R2: A falling SDA while SCL is high (START) begins a new command from any state, including a repeated START. A partly received byte is thrown away and is never written to the array.
- R3: A rising SDA while SCL is high (STOP) returns the block to idle. A byte cut short by a STOP is not stored.
- R4: The control byte is bits[7:4] = 4'b1010, bits[3:1] = the parameter `DEV_SEL`, and bit 0 = direction (1 = read). A matching control byte is acknowledged on the ninth SCL pulse by `sda_oe` = 1 during that pulse's high phase.
- R5: `sda_oe` changes only in the cycle after a detected SCL falling edge, or when a START or STOP is detected. Pin edges are detected after a synchroniser of `SYNC_STAGES` flops.
- R6: A control byte with the wrong family code or wrong select bits gets no acknowledge. Every later byte up to the next START also gets none, even one that would match.
- R7: In a write, the byte after the control byte sets the pointer from its low 4 bits. Each data byte that follows is acknowledged, stored at the pointer, and advances the pointer, which wraps from 15 to 0.
- R8: A STOP that ends a write in which at least one data byte completed starts a programming cycle of `PROG_CYCLES` clocks. No acknowledge is given while it runs. A STOP with no completed data byte, or after an aborted byte, starts no cycle.
- R9: In a read, the block drives the byte at the pointer MSB-first (`sda_oe` = 1 for a 0 bit, 0 for a 1 bit) and advances the pointer, which wraps from 15 to 0.
- R10: If the master acknowledges a read byte (SDA low on the ninth pulse), the next byte follows. If it does not acknowledge, `sda_oe` stays 0 until the next START or STOP.
- R11: A random read works as follows: a write control byte, an address byte, a repeated START, then a read control byte returns the byte at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock pin as seen at the pad |
| sda_i | input | 1 | Bus data pin as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | Pull-down enable for the data pin; 1 drives the line low |

## Verification
A pin edge reaches the control logic `SYNC_STAGES` + 1 clocks after it happens (three with the default). An acknowledge or read bit therefore appears on `sda_oe` about four clocks after the SCL falling pin edge, and the programming cycle starts one clock after the STOP is detected. The bench holds every SCL phase for ten clocks and reads the wired data line in the middle of each high phase, well after those latencies. While the master drives a bit, the bench checks on every clock that the slave does not drive. It predicts acknowledges from its own model of the array, the pointer and the time since the last programming STOP, and keeps each busy probe hundreds of clocks away from the end of the cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } eep_state_t;

  localparam logic [3:0] EEP_FAMILY = 4'b1010;

  // Control byte decode: family code in the upper nibble, select in [3:1].
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == EEP_FAMILY) && (b[3:1] == sel);
  endfunction

  // Bit to put on the line after the given number of clocked bits (MSB first).
  function automatic logic bit_for_slot(input logic [7:0] b, input logic [2:0] slot);
    return b[3'd7 - slot];
  endfunction

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
          sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (kick)       cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eep_regfile.sv
module eep_regfile #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/eep_link_ctrl.sv
module eep_link_ctrl
  import eep_pkg::*;
#(
  parameter int         DEPTH   = 16,
  parameter logic [2:0] DEV_SEL = 3'b000,
  localparam int        AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_s,
  input  logic          busy,
  input  logic [7:0]    mem_rdata,
  output logic          sda_oe,
  output logic          prog_kick,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output eep_state_t    state,
  output logic [3:0]    bitcnt
);
  logic [7:0]    shreg, txreg;
  logic [AW-1:0] ptr;
  logic          wrote, rd_go;
  logic          byte_end, frame_end;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign byte_end  = scl_fall && (bitcnt == 4'd8);
  assign frame_end = scl_fall && (bitcnt == 4'd9);
  assign mem_we    = byte_end && (state == ST_WDATA);
  assign mem_addr  = ptr;
  assign mem_wdata = shreg;
  assign prog_kick = stop_ev && wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txreg  <= '0;
      ptr    <= '0;
      wrote  <= 1'b0;
      rd_go  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_CTRL;
      bitcnt <= '0;
      wrote  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      wrote  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          // Low on the ninth pulse: either the master's ACK or this block's own ACK.
          rd_go  <= ~sda_s;
        end
      end else if (byte_end) begin
        sda_oe <= 1'b0;
        unique case (state)
          ST_CTRL: begin
            if (ctrl_hit(shreg, DEV_SEL) && !busy) begin
              sda_oe <= 1'b1;
              state  <= shreg[0] ? ST_RDATA : ST_WADDR;
            end else begin
              state  <= ST_SKIP;
            end
          end
          ST_WADDR: begin
            ptr    <= shreg[AW-1:0];
            sda_oe <= 1'b1;
            state  <= ST_WDATA;
          end
          ST_WDATA: begin
            ptr    <= ptr_next(ptr);
            wrote  <= 1'b1;
            sda_oe <= 1'b1;
          end
          default: ;
        endcase
      end else if (frame_end) begin
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (state == ST_RDATA) begin
          if (rd_go) begin
            txreg  <= mem_rdata;
            ptr    <= ptr_next(ptr);
            sda_oe <= ~mem_rdata[7];
          end else begin
            state  <= ST_SKIP;
          end
        end
      end else if (scl_fall && (bitcnt != 4'd0) && (state == ST_RDATA)) begin
        sda_oe <= ~bit_for_slot(txreg, bitcnt[2:0]);
      end
    end
  end
endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave
  import eep_pkg::*;
#(
  parameter int         DEPTH       = 16,
  parameter int         PROG_CYCLES = 2000,
  parameter logic [2:0] DEV_SEL     = 3'b000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          busy, prog_kick, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  eep_state_t    state;
  logic [3:0]    bitcnt;

  eep_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_link_ctrl #(.DEPTH(DEPTH), .DEV_SEL(DEV_SEL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s), .busy(busy),
    .mem_rdata(mem_rdata), .sda_oe(sda_oe), .prog_kick(prog_kick),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .state(state), .bitcnt(bitcnt)
  );

  eep_busy_timer #(.CYCLES(PROG_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick(prog_kick), .busy(busy)
  );

  eep_regfile #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/eep_2w_slave_chk.sv
module eep_2w_slave_chk
  import eep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       sda_oe,
  input logic       busy,
  input eep_state_t state,
  input logic [3:0] bitcnt
);
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_CTRL) && (bitcnt == 4'd0));

  a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE));

  a_r5_oe_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev));

  a_r8_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(busy));

  a_r8_prog_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  a_r10_bitcnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (bitcnt == 4'd9) |=> (bitcnt == 4'd9) || (bitcnt == 4'd0));
endmodule

bind eep_2w_slave eep_2w_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .busy(busy), .state(state),
  .bitcnt(bitcnt)
);

// File: tb/eep_2w_slave_tb.sv
module eep_2w_slave_tb;
  localparam int Q    = 10;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  wire  sda_oe;
  wire  sda_line = msda & ~sda_oe;

  always #5 clk = ~clk;

  eep_2w_slave #(.DEPTH(16), .PROG_CYCLES(BUSY), .DEV_SEL(3'b000), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int viol = 0;
  bit must_release = 1'b0;

  // Reference model
  int  mem_m [16];
  int  ptr_m = 0;
  bit  wrote_m = 1'b0;
  int  busy_until = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Per-clock comparison: slave must not drive while master owns the line.
  always @(negedge clk) if (must_release && sda_oe) viol <= viol + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; tick(Q);
    scl  = 1'b1; tick(Q);
    msda = 1'b0; tick(Q);
    scl  = 1'b0; tick(Q);
    wrote_m = 1'b0;
  endtask

  task automatic bus_stop();
    msda = 1'b0; tick(Q);
    scl  = 1'b1; tick(Q);
    msda = 1'b1; tick(Q);
    if (wrote_m) busy_until = cyc + BUSY + 8;
    wrote_m = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    msda = b; tick(Q);
    must_release = 1'b1;
    scl = 1'b1; tick(2*Q);
    must_release = 1'b0;
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output bit b);
    msda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, input bit exp_ack, input string req);
    int base;
    bit b;
    base = viol;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    chk(viol == base, req, viol - base, 0);
    chk((!b) == exp_ack, req, int'(!b), int'(exp_ack));
  endtask

  task automatic read_byte(input bit mack, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!mack);
    chk(d == exp, req, d, exp);
  endtask

  function automatic bit busy_now();
    return (cyc + 40*Q) < busy_until;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    // R1/R9: read at reset pointer 0 returns erased value
    bus_start();
    write_byte(8'hA1, 1'b1, "R4 read control ack");
    read_byte(1'b0, 8'h00, "R1 reset contents");
    ptr_m = 1;
    tick(2);
    chk(sda_oe == 1'b0, "R10 released after NACK", sda_oe, 0);
    bus_stop();

    // R7: byte write at 3
    bus_start();
    write_byte(8'hA0, 1'b1, "R4 write control ack");
    write_byte(8'h03, 1'b1, "R7 address ack");
    write_byte(8'hA5, 1'b1, "R7 data ack");
    mem_m[3] = 8'hA5; ptr_m = 4; wrote_m = 1'b1;
    bus_stop();

    // R8: NACK while programming; R6: following byte ignored
    bus_start();
    write_byte(8'hA0, !busy_now(), "R8 no ack while busy");
    write_byte(8'h55, 1'b0, "R6 skip after refused control");
    bus_stop();
    tick(BUSY + 100);

    // R11: random read of address 3
    bus_start();
    write_byte(8'hA0, !busy_now(), "R11 write control");
    write_byte(8'h03, 1'b1, "R11 address");
    bus_start();
    write_byte(8'hA1, 1'b1, "R11 read control after repeated START");
    read_byte(1'b0, mem_m[3], "R11 random read data");
    chk(sda_oe == 1'b0, "R10 released after last byte", sda_oe, 0);
    bus_stop();

    // R7: sequential write wrapping 15 -> 0
    bus_start();
    write_byte(8'hA0, 1'b1, "R7 control");
    write_byte(8'h0E, 1'b1, "R7 address 14");
    write_byte(8'h11, 1'b1, "R7 data 14");
    write_byte(8'h22, 1'b1, "R7 data 15");
    write_byte(8'h33, 1'b1, "R7 data wrap 0");
    mem_m[14] = 8'h11; mem_m[15] = 8'h22; mem_m[0] = 8'h33; wrote_m = 1'b1;
    bus_stop();
    tick(BUSY + 100);

    // R9/R10: sequential read with master ACKs, wrap
    bus_start();
    write_byte(8'hA0, 1'b1, "R9 control");
    write_byte(8'h0E, 1'b1, "R9 address 14");
    bus_start();
    write_byte(8'hA1, 1'b1, "R9 read control");
    read_byte(1'b1, mem_m[14], "R10 first byte then ACK");
    read_byte(1'b1, mem_m[15], "R9 second byte");
    read_byte(1'b0, mem_m[0], "R9 wrapped byte");
    bus_stop();

    // R6: wrong family code
    bus_start();
    write_byte(8'hB0, 1'b0, "R6 wrong code");
    write_byte(8'hA0, 1'b0, "R6 ignored until START");
    bus_stop();

    // R4: wrong select bits
    bus_start();
    write_byte(8'hA2, 1'b0, "R4 wrong select");
    bus_stop();

    // R8: STOP after address only starts no programming
    bus_start();
    write_byte(8'hA0, 1'b1, "R8 control");
    write_byte(8'h05, 1'b1, "R8 address only");
    bus_stop();
    bus_start();
    write_byte(8'hA0, 1'b1, "R8 no programming without data");
    write_byte(8'h05, 1'b1, "R2 address 5");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    write_byte(8'hA1, 1'b1, "R2 control after abort");
    read_byte(1'b0, 8'h00, "R2 aborted byte not stored");
    bus_stop();

    // R3: STOP mid-byte aborts and starts no programming
    bus_start();
    write_byte(8'hA0, 1'b1, "R3 control");
    write_byte(8'h07, 1'b1, "R3 address 7");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    bus_start();
    write_byte(8'hA0, 1'b1, "R3 no programming after cut byte");
    write_byte(8'h07, 1'b1, "R3 address again");
    bus_start();
    write_byte(8'hA1, 1'b1, "R3 read control");
    read_byte(1'b0, 8'h00, "R3 cut byte not stored");
    bus_stop();
    tick(20);
    chk(sda_oe == 1'b0, "R3 idle after STOP", sda_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule